// File: doc/BRIEF.md
# Edge-Captured Interrupt Flag Register

This block collects a set of external, active-low interrupt requests into a register of sticky flags that a CPU can read and acknowledge over a simple strobe-based bus. Every request pin is inverted, so an asserted request is a 1 inside the block. It is then brought into the system clock domain through a chain of synchronizer flops and compared against a delayed copy of itself. A falling edge on the pin sets the matching flag. The flag stays set until software clears it, whatever the pin does afterwards.

The CPU reads all flags at once. The read data carries its own output-enable, which is high only while chip select is asserted and the read strobe is low, so an external pad or bus multiplexer can use it directly. An acknowledge is a bus write in which each 1 bit clears the matching flag and each 0 bit leaves it alone. Software can therefore write back exactly the value it read and keep any request that arrived in the meantime. A write strobe held for many clocks acts only once. A new edge that lands in the same cycle as the clear of its own bit wins over the clear. An interrupt line to the CPU is the registered OR of all flags.

Top module: `irq_flag_reg`

## Requirements
- R1: While reset is applied and right after it, every flag reads 0, `irq` is 0 and `rdata` is 0.
- R2: A falling edge on `req_n[i]` sets flag bit i, visible on `rdata[i]` after SYNC_STAGES+1 rising clock edges. A rising edge on a request pin sets nothing. Several pins falling together set all their bits.
- R3: A set flag stays set while its pin returns high. A pin held low sets its flag only once: after a clear, the flag stays 0 while the pin remains low.
- R4: A write (`cs`=1 and `wr_n`=0) clears each flag whose `wdata` bit is 1 and leaves flags whose bit is 0 unchanged. A write of all ones clears every flag.
- R5: When a new edge and a clear hit the same bit in the same clock cycle, the flag ends up set.
- R6: A write acts in the first clock cycle of the bus write only. A new edge that arrives while the same write is still held sets its flag, and the flag stays set.
- R7: `rdata_oe` is 1 exactly when `cs`=1 and `rd_n`=0. `rdata` shows the flags while `rdata_oe` is 1 and is all zeros otherwise.
- R8: `irq` equals the OR of all flags, delayed by one clock. It stays 1 after an acknowledge that leaves any flag set.
- R9: A request pulse held low for at least two clocks is captured.
- R10: Writing back the value read clears only those flags. A request captured after the read stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_n | input | NUM_REQ | Active-low asynchronous interrupt requests |
| cs | input | 1 | Chip select for this register, active high |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| wdata | input | NUM_REQ | Acknowledge mask; each 1 clears the matching flag |
| rdata | output | NUM_REQ | Flag read data, zero when not enabled |
| rdata_oe | output | 1 | Read data output-enable |
| irq | output | 1 | Registered OR of all flags |

## Verification
The bench builds the block with its default parameters: eight request lines and two synchronizer stages ahead of the edge-sense pair. Under those settings a request shows up as a flag three clock edges after the pin falls, and `irq` follows one edge later. This lets the bench place a clear in exactly the cycle that the edge comparison fires for the same bit. It can also hold a write open across a complete capture and test a two-clock pulse at the shortest width the chain can still see. Eight bits are enough to mix set, cleared and untouched flags in one acknowledge and to check an all-ones clear.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  // Qualified bus controls derived from the raw strobes.
  typedef struct packed {
    logic wr_pulse;   // one clock per bus write
    logic rd_en;      // read data enable
  } bus_ctl_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int NUM_REQ     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_n,
  output logic [NUM_REQ-1:0] edge_hit
);

  localparam int LAST = SYNC_STAGES - 1;

  for (genvar b = 0; b < NUM_REQ; b++) begin : g_bit
    logic [SYNC_STAGES-1:0] sync_q;
    logic [SYNC_STAGES-1:0] sync_d;
    logic                   older_q;
    logic                   older_d;

    always_comb begin
      sync_d[0] = ~req_n[b];
      for (int k = 1; k < SYNC_STAGES; k++) begin
        sync_d[k] = sync_q[k-1];
      end
      older_d = sync_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q  <= '0;
        older_q <= 1'b0;
      end else begin
        sync_q  <= sync_d;
        older_q <= older_d;
      end
    end

    // Newer sample high, older sample low: the pin has fallen.
    assign edge_hit[b] = sync_q[LAST] & ~older_q;
  end

endmodule

// File: rtl/irq_bus_qual.sv
module irq_bus_qual
  import irq_flag_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs,
  input  logic     wr_n,
  input  logic     rd_n,
  output bus_ctl_t ctl
);

  logic wr_req;
  logic wr_seen_q;
  logic wr_seen_d;

  always_comb begin
    wr_req       = cs & ~wr_n;
    wr_seen_d    = wr_req;
    ctl.wr_pulse = wr_req & ~wr_seen_q;
    ctl.rd_en    = cs & ~rd_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_seen_q <= 1'b0;
    else        wr_seen_q <= wr_seen_d;
  end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_REQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] set_i,
  input  logic               clr_en,
  input  logic [NUM_REQ-1:0] clr_mask,
  output logic [NUM_REQ-1:0] flags_o,
  output logic               irq_o
);

  logic [NUM_REQ-1:0] flags_q;
  logic [NUM_REQ-1:0] flags_d;
  logic [NUM_REQ-1:0] clr_eff;
  logic               irq_q;
  logic               irq_d;

  always_comb begin
    clr_eff = clr_en ? clr_mask : '0;
    // Clear first, then set: a coincident edge survives.
    flags_d = (flags_q & ~clr_eff) | set_i;
    irq_d   = |flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= irq_d;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_flag_pkg::*;
#(
  parameter int NUM_REQ     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_n,
  input  logic               cs,
  input  logic               wr_n,
  input  logic               rd_n,
  input  logic [NUM_REQ-1:0] wdata,
  output logic [NUM_REQ-1:0] rdata,
  output logic               rdata_oe,
  output logic               irq
);

  logic               rst_sync_n;
  logic [NUM_REQ-1:0] edge_hit;
  logic [NUM_REQ-1:0] flags;
  bus_ctl_t           bus_ctl;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_edge_capture #(.NUM_REQ(NUM_REQ), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_n    (req_n),
    .edge_hit (edge_hit)
  );

  irq_bus_qual u_bus (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cs    (cs),
    .wr_n  (wr_n),
    .rd_n  (rd_n),
    .ctl   (bus_ctl)
  );

  irq_flag_bank #(.NUM_REQ(NUM_REQ)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_i    (edge_hit),
    .clr_en   (bus_ctl.wr_pulse),
    .clr_mask (wdata),
    .flags_o  (flags),
    .irq_o    (irq)
  );

  assign rdata_oe = bus_ctl.rd_en;
  assign rdata    = bus_ctl.rd_en ? flags : '0;

endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk #(
  parameter int NUM_REQ = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REQ-1:0] flags,
  input logic [NUM_REQ-1:0] edge_hit,
  input logic               wr_pulse,
  input logic [NUM_REQ-1:0] wdata,
  input logic               irq
);

  // R3: without a write pulse no flag drops
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> ((flags & $past(flags)) == $past(flags)));

  // R2 and R5: a detected edge always leaves its flag set, even against a clear
  a_r5_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((flags & $past(edge_hit)) == $past(edge_hit)));

  // R4: a write pulse clears the masked bits that saw no new edge
  a_r4_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> ((flags & $past(wdata & ~edge_hit)) == '0));

  // R6: the qualified write lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R8: interrupt output follows the flag OR one clock later
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|flags)));

endmodule

bind irq_flag_reg irq_flag_reg_chk #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .flags    (flags),
  .edge_hit (edge_hit),
  .wr_pulse (bus_ctl.wr_pulse),
  .wdata    (wdata),
  .irq      (irq)
);

// File: tb/tb_irq_flag_reg.sv
module tb_irq_flag_reg;

  localparam int N   = 8;
  localparam int LAT = 3; // SYNC_STAGES + 1 edges from pin to flag

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req_n;
  logic         cs;
  logic         wr_n;
  logic         rd_n;
  logic [N-1:0] wdata;
  logic [N-1:0] rdata;
  logic         rdata_oe;
  logic         irq;

  int checks;
  int failures;
  bit done;

  irq_flag_reg dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_n    (req_n),
    .cs       (cs),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .wdata    (wdata),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic read_flags(output logic [N-1:0] val);
    cs   = 1'b1;
    rd_n = 1'b0;
    #1;
    val  = rdata;
    cs   = 1'b0;
    rd_n = 1'b1;
    #1;
  endtask

  task automatic write_ack(input logic [N-1:0] mask);
    cs    = 1'b1;
    wr_n  = 1'b0;
    wdata = mask;
    tick(1);
    cs    = 1'b0;
    wr_n  = 1'b1;
    wdata = '0;
  endtask

  task automatic t_reset;
    logic [N-1:0] v;
    rst_n = 1'b0;
    tick(3);
    read_flags(v);
    check("R1 flags in reset", v, 0);
    check("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    tick(6);
    read_flags(v);
    check("R1 flags after reset", v, 0);
    check("R1 irq after reset", irq, 0);
  endtask

  task automatic t_read_port;
    logic [N-1:0] v;
    cs = 1'b0; rd_n = 1'b0; #1;
    check("R7 oe without cs", rdata_oe, 0);
    cs = 1'b1; rd_n = 1'b1; #1;
    check("R7 oe without rd", rdata_oe, 0);
    rd_n = 1'b0; #1;
    check("R7 oe with cs and rd", rdata_oe, 1);
    cs = 1'b0; rd_n = 1'b1; #1;
    req_n[1] = 1'b0;
    tick(LAT + 1);
    #1;
    check("R7 rdata zero when disabled", rdata, 0);
    read_flags(v);
    check("R7 rdata shows flags", v, 8'h02);
    req_n[1] = 1'b1;
    tick(4);
    write_ack('1);
    tick(1);
  endtask

  task automatic t_capture;
    logic [N-1:0] v;
    req_n = ~8'h5A;
    tick(LAT - 1);
    read_flags(v);
    check("R2 not yet visible", v, 0);
    tick(1);
    read_flags(v);
    check("R2 multi-bit capture latency", v, 8'h5A);
    check("R8 irq lags flags", irq, 0);
    tick(1);
    check("R8 irq raised", irq, 1);
    req_n = '1;
    tick(5);
    read_flags(v);
    check("R3 flags stay after pin rises", v, 8'h5A);
    write_ack(8'h0A);
    read_flags(v);
    check("R4 selective clear", v, 8'h50);
    tick(1);
    check("R8 irq stays with flags left", irq, 1);
    write_ack('1);
    read_flags(v);
    check("R4 all-ones clear", v, 0);
    tick(2);
    check("R2 rising edge sets nothing", irq, 0);
  endtask

  task automatic t_held_low;
    logic [N-1:0] v;
    req_n[3] = 1'b0;
    tick(LAT + 1);
    read_flags(v);
    check("R3 held low sets", v, 8'h08);
    write_ack(8'h08);
    tick(6);
    read_flags(v);
    check("R3 held low sets once", v, 0);
    check("R8 irq low after ack", irq, 0);
    req_n[3] = 1'b1;
    tick(4);
  endtask

  task automatic t_short_pulse;
    logic [N-1:0] v;
    req_n[4] = 1'b0;
    tick(2);
    req_n[4] = 1'b1;
    tick(3);
    read_flags(v);
    check("R9 two-clock pulse captured", v, 8'h10);
    write_ack('1);
    tick(2);
  endtask

  task automatic t_collision;
    logic [N-1:0] v;
    req_n[2] = 1'b0;
    tick(LAT + 1);
    req_n[2] = 1'b1;
    tick(5);
    read_flags(v);
    check("R5 setup flag", v, 8'h04);
    req_n[2] = 1'b0;
    tick(LAT - 1);
    write_ack(8'h04);   // clear lands in the edge cycle
    read_flags(v);
    check("R5 new edge survives clear", v, 8'h04);
    req_n[2] = 1'b1;
    tick(4);
    write_ack('1);
    tick(2);
  endtask

  task automatic t_long_write;
    logic [N-1:0] v;
    req_n[0] = 1'b0;
    tick(LAT + 1);
    req_n[0] = 1'b1;
    tick(4);
    cs = 1'b1; wr_n = 1'b0; wdata = 8'h01;
    tick(1);
    rd_n = 1'b0; #1;
    check("R6 first cycle clears", rdata, 0);
    rd_n = 1'b1;
    req_n[0] = 1'b0;
    tick(LAT + 2);
    rd_n = 1'b0; #1;
    check("R6 held write clears once", rdata, 8'h01);
    rd_n = 1'b1;
    cs = 1'b0; wr_n = 1'b1; wdata = '0;
    req_n[0] = 1'b1;
    tick(4);
    write_ack('1);
    tick(2);
  endtask

  task automatic t_writeback;
    logic [N-1:0] seen;
    logic [N-1:0] v;
    req_n[5] = 1'b0;
    req_n[6] = 1'b0;
    tick(LAT + 1);
    req_n[5] = 1'b1;
    req_n[6] = 1'b1;
    read_flags(seen);
    check("R10 read snapshot", seen, 8'h60);
    req_n[7] = 1'b0;
    tick(LAT + 1);
    write_ack(seen);
    read_flags(v);
    check("R10 later request pending", v, 8'h80);
    tick(1);
    check("R10 irq still high", irq, 1);
    req_n[7] = 1'b1;
    tick(4);
    write_ack('1);
    tick(2);
    check("R8 irq drops when empty", irq, 0);
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    req_n = '1; cs = 1'b0; wr_n = 1'b1; rd_n = 1'b1; wdata = '0;
    rst_n = 1'b0;
    tick(1);
    t_reset();
    t_read_port();
    t_capture();
    t_held_low();
    t_short_pulse();
    t_collision();
    t_long_write();
    t_writeback();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule